// File: doc/BRIEF.md
# Exception Entry Vector Unit

This block holds the exception-entry state of a 64-bit processor core and produces the fetch address that the core jumps to when it takes an exception. When the exception strobe is high, the block picks one of four absolute vector addresses and subtracts the base of the active code capability from it. The result is the next PC. Fetching relative to the new code capability then arrives at the correct absolute vector. In the same clock edge it saves the return address and the delay-slot flag, loads a 5-bit cause code and sets the exception-level bit.

When the exception-return strobe is high, the block clears the exception level and drives the saved return address out as the next PC. Instruction decode, address translation, the capability registers and the pipeline flush belong to the surrounding core. The core samples `next_pc_o` in the cycle after it raises either strobe.

Top module: `exc_entry_unit`

## Requirements
- R1: After synchronous reset, next_pc_o, epc_o, bd_o, cause_code_o and exl_o are all zero.
- R2: The absolute vector base is 0xFFFFFFFFBFC00200 when boot_vec_i is 1 and 0xFFFFFFFF80000000 when boot_vec_i is 0.
- R3: The vector offset is 0x000 for a TLB refill kind (exc_kind_i 4 or 5) taken while exl_o is 0. It is 0x180 for every other exception, including a refill kind taken while exl_o is 1.
- R4: On an exception, next_pc_o becomes (base + offset - code_base_i) modulo 2^64 in the cycle after the strobe. With code_base_i zero this is the plain absolute vector.
- R5: An exception taken while exl_o is 0 loads epc_o with fault_pc_i - 4 (modulo 2^64) and sets bd_o when in_delay_i is 1. When in_delay_i is 0 it loads fault_pc_i and clears bd_o.
- R6: An exception taken while exl_o is 1 leaves epc_o and bd_o unchanged.
- R7: exc_kind_i maps to cause_code_o as follows: 0 to 0, 1 to 1, 2 to 2, 3 to 3, 4 to 2, 5 to 3, 6 to 4, 7 to 5, 8 to 8, 9 to 9, 10 to 10, 11 to 12, 12 to 13. The unused kinds 13 to 15 map to 10.
- R8: Every exception sets exl_o to 1.
- R9: eret_i without exc_take_i clears exl_o and loads next_pc_o with the current epc_o. epc_o, bd_o and cause_code_o stay unchanged.
- R10: When exc_take_i and eret_i are high in the same cycle, the exception is taken and the return is ignored.
- R11: In a cycle with both strobes low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_take_i | input | 1 | Exception taken in this cycle |
| exc_kind_i | input | 4 | Exception kind, encoded as in R7 |
| fault_pc_i | input | 64 | PC of the faulting instruction |
| in_delay_i | input | 1 | Faulting instruction sits in a branch delay slot |
| boot_vec_i | input | 1 | Selects the boot vector base |
| code_base_i | input | 64 | Base of the code capability used after entry |
| eret_i | input | 1 | Exception return in this cycle |
| next_pc_o | output | 64 | Redirect fetch address |
| epc_o | output | 64 | Saved exception return address |
| bd_o | output | 1 | Saved branch-delay flag |
| cause_code_o | output | 5 | Cause exception code |
| exl_o | output | 1 | Exception level bit |

## Verification
On every cycle the assertions check these relations: the redirect address plus the previous capability base always equals one of the two vectors of the selected base; EPC and BD stay frozen under a nested exception; a lone return clears the level and redirects to EPC; a colliding pair leaves the level set; an idle cycle changes nothing. The offset choice for a refill, which depends on the level bit, is shown only by the bench scenarios, and so are the full cause table, the wrap of PC - 4 below zero and the wrap of the subtraction when the capability base exceeds the vector.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

    localparam logic [31:0] BOOT_BASE_LO = 32'hBFC0_0200;
    localparam logic [31:0] NORM_BASE_LO = 32'h8000_0000;
    localparam int unsigned OFF_W        = 12;
    localparam logic [OFF_W-1:0] OFF_REFILL  = 12'h000;
    localparam logic [OFF_W-1:0] OFF_GENERAL = 12'h180;
    localparam int unsigned CODE_W       = 5;

    typedef enum logic [3:0] {
        K_INT        = 4'd0,
        K_TLB_MOD    = 4'd1,
        K_TLB_LD     = 4'd2,
        K_TLB_ST     = 4'd3,
        K_REFILL_LD  = 4'd4,
        K_REFILL_ST  = 4'd5,
        K_ADDR_LD    = 4'd6,
        K_ADDR_ST    = 4'd7,
        K_SYSCALL    = 4'd8,
        K_BREAK      = 4'd9,
        K_RSVD_INSN  = 4'd10,
        K_OVERFLOW   = 4'd11,
        K_TRAP       = 4'd12,
        K_SPARE0     = 4'd13,
        K_SPARE1     = 4'd14,
        K_SPARE2     = 4'd15
    } exc_kind_e;

    typedef struct packed {
        logic              refill;
        logic [CODE_W-1:0] code;
    } kind_info_t;

    function automatic kind_info_t decode_kind(exc_kind_e k);
        kind_info_t r;
        r.refill = 1'b0;
        unique case (k)
            K_INT:       r.code = 5'd0;
            K_TLB_MOD:   r.code = 5'd1;
            K_TLB_LD:    r.code = 5'd2;
            K_TLB_ST:    r.code = 5'd3;
            K_REFILL_LD: begin r.code = 5'd2; r.refill = 1'b1; end
            K_REFILL_ST: begin r.code = 5'd3; r.refill = 1'b1; end
            K_ADDR_LD:   r.code = 5'd4;
            K_ADDR_ST:   r.code = 5'd5;
            K_SYSCALL:   r.code = 5'd8;
            K_BREAK:     r.code = 5'd9;
            K_OVERFLOW:  r.code = 5'd12;
            K_TRAP:      r.code = 5'd13;
            default:     r.code = 5'd10;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/exc_vec_target.sv
module exc_vec_target
    import exc_vec_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            boot_sel,
    input  logic            refill_sel,
    input  logic [XLEN-1:0] code_base,
    output logic [XLEN-1:0] target
);
    localparam int unsigned HI_W = XLEN - 32;
    localparam logic [XLEN-1:0] BOOT_BASE =
        {{HI_W{BOOT_BASE_LO[31]}}, BOOT_BASE_LO};
    localparam logic [XLEN-1:0] NORM_BASE =
        {{HI_W{NORM_BASE_LO[31]}}, NORM_BASE_LO};

    logic [OFF_W-1:0] offset;
    logic [XLEN-1:0]  base;
    logic [XLEN-1:0]  absolute;

    always_comb begin
        offset   = refill_sel ? OFF_REFILL : OFF_GENERAL;
        base     = boot_sel ? BOOT_BASE : NORM_BASE;
        absolute = base + {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset};
        target   = absolute - code_base;
    end
endmodule

// File: rtl/exc_save_calc.sv
module exc_save_calc #(
    parameter int unsigned XLEN       = 64,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic [XLEN-1:0] fault_pc,
    input  logic            in_delay,
    output logic [XLEN-1:0] save_pc,
    output logic            save_bd
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    always_comb begin
        save_pc = in_delay ? (fault_pc - STEP) : fault_pc;
        save_bd = in_delay;
    end
endmodule

// File: rtl/exc_cp0_state.sv
module exc_cp0_state #(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              ret,
    input  logic [XLEN-1:0]   target,
    input  logic [XLEN-1:0]   save_pc,
    input  logic              save_bd,
    input  logic [CODE_W-1:0] code,
    output logic [XLEN-1:0]   next_pc,
    output logic [XLEN-1:0]   epc,
    output logic              bd,
    output logic [CODE_W-1:0] cause,
    output logic              exl
);
    logic save_en;
    assign save_en = take && !exl;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc <= '0;
            epc     <= '0;
            bd      <= 1'b0;
            cause   <= '0;
            exl     <= 1'b0;
        end else if (take) begin
            next_pc <= target;
            cause   <= code;
            exl     <= 1'b1;
            if (save_en) begin
                epc <= save_pc;
                bd  <= save_bd;
            end
        end else if (ret) begin
            next_pc <= epc;
            exl     <= 1'b0;
        end
    end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_vec_pkg::*;
#(
    parameter int unsigned XLEN       = 64,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_take_i,
    input  logic [3:0]        exc_kind_i,
    input  logic [XLEN-1:0]   fault_pc_i,
    input  logic              in_delay_i,
    input  logic              boot_vec_i,
    input  logic [XLEN-1:0]   code_base_i,
    input  logic              eret_i,
    output logic [XLEN-1:0]   next_pc_o,
    output logic [XLEN-1:0]   epc_o,
    output logic              bd_o,
    output logic [CODE_W-1:0] cause_code_o,
    output logic              exl_o
);
    kind_info_t      info;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] save_pc;
    logic            save_bd;

    assign info = decode_kind(exc_kind_e'(exc_kind_i));

    exc_vec_target #(.XLEN(XLEN)) u_target (
        .boot_sel   (boot_vec_i),
        .refill_sel (info.refill && !exl_o),
        .code_base  (code_base_i),
        .target     (target)
    );

    exc_save_calc #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_save (
        .fault_pc (fault_pc_i),
        .in_delay (in_delay_i),
        .save_pc  (save_pc),
        .save_bd  (save_bd)
    );

    exc_cp0_state #(.XLEN(XLEN), .CODE_W(CODE_W)) u_state (
        .clk     (clk),
        .rst     (rst),
        .take    (exc_take_i),
        .ret     (eret_i),
        .target  (target),
        .save_pc (save_pc),
        .save_bd (save_bd),
        .code    (info.code),
        .next_pc (next_pc_o),
        .epc     (epc_o),
        .bd      (bd_o),
        .cause   (cause_code_o),
        .exl     (exl_o)
    );
endmodule

// File: rtl/exc_entry_unit_chk.sv
module exc_entry_unit_chk
    import exc_vec_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              exc_take_i,
    input logic [3:0]        exc_kind_i,
    input logic [XLEN-1:0]   fault_pc_i,
    input logic              in_delay_i,
    input logic              boot_vec_i,
    input logic [XLEN-1:0]   code_base_i,
    input logic              eret_i,
    input logic [XLEN-1:0]   next_pc_o,
    input logic [XLEN-1:0]   epc_o,
    input logic              bd_o,
    input logic [CODE_W-1:0] cause_code_o,
    input logic              exl_o
);
    localparam logic [XLEN-1:0] BOOT_A = {{(XLEN-32){1'b1}}, 32'hBFC0_0200};
    localparam logic [XLEN-1:0] BOOT_B = {{(XLEN-32){1'b1}}, 32'hBFC0_0380};
    localparam logic [XLEN-1:0] NORM_A = {{(XLEN-32){1'b1}}, 32'h8000_0000};
    localparam logic [XLEN-1:0] NORM_B = {{(XLEN-32){1'b1}}, 32'h8000_0180};

    // R2, R4: redirect plus old capability base lands on a vector of the chosen base
    a_r4_boot_target: assert property (@(posedge clk) disable iff (rst)
        exc_take_i && boot_vec_i |=>
            ((next_pc_o + $past(code_base_i)) == BOOT_A) ||
            ((next_pc_o + $past(code_base_i)) == BOOT_B));

    a_r2_norm_target: assert property (@(posedge clk) disable iff (rst)
        exc_take_i && !boot_vec_i |=>
            ((next_pc_o + $past(code_base_i)) == NORM_A) ||
            ((next_pc_o + $past(code_base_i)) == NORM_B));

    a_r5_plain_save: assert property (@(posedge clk) disable iff (rst)
        exc_take_i && !exl_o && !in_delay_i |=>
            (epc_o == $past(fault_pc_i)) && !bd_o);

    a_r6_nested_hold: assert property (@(posedge clk) disable iff (rst)
        exc_take_i && exl_o |=> $stable(epc_o) && $stable(bd_o));

    a_r7_syscall_code: assert property (@(posedge clk) disable iff (rst)
        exc_take_i && (exc_kind_i == 4'd8) |=> cause_code_o == 5'd8);

    a_r7_legal_code: assert property (@(posedge clk) disable iff (rst)
        exc_take_i |=> (cause_code_o <= 5'd5) || (cause_code_o == 5'd8) ||
            (cause_code_o == 5'd9) || (cause_code_o == 5'd10) ||
            (cause_code_o == 5'd12) || (cause_code_o == 5'd13));

    a_r8_exl_set: assert property (@(posedge clk) disable iff (rst)
        exc_take_i |=> exl_o);

    a_r9_return: assert property (@(posedge clk) disable iff (rst)
        eret_i && !exc_take_i |=>
            !exl_o && (next_pc_o == $past(epc_o)) && $stable(epc_o) &&
            $stable(bd_o) && $stable(cause_code_o));

    a_r10_collision: assert property (@(posedge clk) disable iff (rst)
        exc_take_i && eret_i |=> exl_o);

    a_r11_idle: assert property (@(posedge clk) disable iff (rst)
        !exc_take_i && !eret_i |=>
            $stable(next_pc_o) && $stable(epc_o) && $stable(bd_o) &&
            $stable(cause_code_o) && $stable(exl_o));
endmodule

bind exc_entry_unit exc_entry_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .exc_take_i   (exc_take_i),
    .exc_kind_i   (exc_kind_i),
    .fault_pc_i   (fault_pc_i),
    .in_delay_i   (in_delay_i),
    .boot_vec_i   (boot_vec_i),
    .code_base_i  (code_base_i),
    .eret_i       (eret_i),
    .next_pc_o    (next_pc_o),
    .epc_o        (epc_o),
    .bd_o         (bd_o),
    .cause_code_o (cause_code_o),
    .exl_o        (exl_o)
);

// File: tb/sim_exc_entry_unit.sv
`timescale 1ns/1ps
module sim_exc_entry_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        exc_take_i, in_delay_i, boot_vec_i, eret_i;
    logic [3:0]  exc_kind_i;
    logic [63:0] fault_pc_i, code_base_i;
    logic [63:0] next_pc_o, epc_o;
    logic        bd_o, exl_o;
    logic [4:0]  cause_code_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [63:0] m_npc, m_epc;
    logic        m_bd, m_exl;
    logic [4:0]  m_code;

    always #2.5 clk = ~clk;

    exc_entry_unit u0 (
        .clk(clk), .rst(rst), .exc_take_i(exc_take_i), .exc_kind_i(exc_kind_i),
        .fault_pc_i(fault_pc_i), .in_delay_i(in_delay_i), .boot_vec_i(boot_vec_i),
        .code_base_i(code_base_i), .eret_i(eret_i), .next_pc_o(next_pc_o),
        .epc_o(epc_o), .bd_o(bd_o), .cause_code_o(cause_code_o), .exl_o(exl_o)
    );

    function automatic logic [4:0] want_code(input logic [3:0] k);
        case (k)
            4'd0: return 5'd0;   4'd1: return 5'd1;   4'd2: return 5'd2;
            4'd3: return 5'd3;   4'd4: return 5'd2;   4'd5: return 5'd3;
            4'd6: return 5'd4;   4'd7: return 5'd5;   4'd8: return 5'd8;
            4'd9: return 5'd9;   4'd10: return 5'd10; 4'd11: return 5'd12;
            4'd12: return 5'd13; default: return 5'd10;
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "next_pc", next_pc_o, m_npc);
        check(tag, "epc", epc_o, m_epc);
        check(tag, "bd", 64'(bd_o), 64'(m_bd));
        check(tag, "cause", 64'(cause_code_o), 64'(m_code));
        check(tag, "exl", 64'(exl_o), 64'(m_exl));
    endtask

    // Drive one cycle of stimulus, update the model, check after the edge.
    task automatic step(input string tag, input logic exc, input logic [3:0] kind,
                        input logic [63:0] pc, input logic dly, input logic boot,
                        input logic [63:0] cbase, input logic ret);
        logic [63:0] basev, offv;
        @(negedge clk);
        exc_take_i = exc; exc_kind_i = kind; fault_pc_i = pc; in_delay_i = dly;
        boot_vec_i = boot; code_base_i = cbase; eret_i = ret;
        if (exc) begin
            basev = boot ? 64'hFFFF_FFFF_BFC0_0200 : 64'hFFFF_FFFF_8000_0000;
            offv  = ((kind == 4'd4 || kind == 4'd5) && !m_exl) ? 64'h0 : 64'h180;
            m_npc = basev + offv - cbase;
            if (!m_exl) begin
                m_epc = dly ? pc - 64'd4 : pc;
                m_bd  = dly;
            end
            m_code = want_code(kind);
            m_exl  = 1'b1;
        end else if (ret) begin
            m_npc = m_epc;
            m_exl = 1'b0;
        end
        @(negedge clk);
        exc_take_i = 1'b0; eret_i = 1'b0;
        check_all(tag);
    endtask

    task automatic t_reset();
        rst = 1'b1; exc_take_i = 0; eret_i = 0; exc_kind_i = 0; fault_pc_i = 0;
        in_delay_i = 0; boot_vec_i = 0; code_base_i = 0;
        m_npc = 0; m_epc = 0; m_bd = 0; m_code = 0; m_exl = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R1");
    endtask

    task automatic t_bases();
        step("R2", 1, 4'd8, 64'h0000_0000_0040_1000, 0, 0, 64'h0, 0);
        check("R4", "abs normal", next_pc_o, 64'hFFFF_FFFF_8000_0180);
        step("R9", 0, 4'd0, 64'h0, 0, 0, 64'h0, 1);
        step("R2", 1, 4'd9, 64'h0000_0000_0040_2000, 0, 1, 64'h0, 0);
        check("R2", "abs boot", next_pc_o, 64'hFFFF_FFFF_BFC0_0380);
        step("R9", 0, 4'd0, 64'h0, 0, 0, 64'h0, 1);
        check("R9", "ret target", next_pc_o, 64'h0000_0000_0040_2000);
    endtask

    task automatic t_refill();
        step("R3", 1, 4'd4, 64'h1234, 0, 0, 64'h0, 0);
        check("R3", "refill normal", next_pc_o, 64'hFFFF_FFFF_8000_0000);
        step("R3", 1, 4'd5, 64'h5678, 0, 1, 64'h0, 0);
        check("R3", "nested refill", next_pc_o, 64'hFFFF_FFFF_BFC0_0380);
        step("R9", 0, 4'd0, 64'h0, 0, 0, 64'h0, 1);
        step("R3", 1, 4'd5, 64'h9999, 0, 1, 64'h0, 0);
        check("R3", "refill boot", next_pc_o, 64'hFFFF_FFFF_BFC0_0200);
        step("R9", 0, 4'd0, 64'h0, 0, 0, 64'h0, 1);
    endtask

    task automatic t_capbase();
        step("R4", 1, 4'd12, 64'h40, 0, 0, 64'hFFFF_FFFF_8000_0000, 0);
        check("R4", "base=vector region", next_pc_o, 64'h180);
        step("R9", 0, 4'd0, 64'h0, 0, 0, 64'h0, 1);
        step("R4", 1, 4'd10, 64'h44, 0, 0, 64'h1000, 0);
        check("R4", "small base", next_pc_o, 64'hFFFF_FFFF_7FFF_F180);
        step("R9", 0, 4'd0, 64'h0, 0, 0, 64'h0, 1);
        step("R4", 1, 4'd1, 64'h48, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        check("R4", "wrap base", next_pc_o, 64'hFFFF_FFFF_BFC0_0381);
        step("R9", 0, 4'd0, 64'h0, 0, 0, 64'h0, 1);
    endtask

    task automatic t_delay();
        step("R5", 1, 4'd6, 64'h1000, 1, 0, 64'h0, 0);
        check("R5", "delay epc", epc_o, 64'hFFC);
        check("R5", "delay bd", 64'(bd_o), 64'h1);
        step("R9", 0, 4'd0, 64'h0, 0, 0, 64'h0, 1);
        step("R5", 1, 4'd7, 64'h0, 1, 0, 64'h0, 0);
        check("R5", "wrap epc", epc_o, 64'hFFFF_FFFF_FFFF_FFFC);
        step("R9", 0, 4'd0, 64'h0, 0, 0, 64'h0, 1);
        step("R5", 1, 4'd3, 64'h2000, 0, 0, 64'h0, 0);
        check("R5", "plain bd", 64'(bd_o), 64'h0);
    endtask

    task automatic t_nested();
        // EXL is 1 here from t_delay
        step("R6", 1, 4'd11, 64'hDEAD_0000, 1, 0, 64'h0, 0);
        check("R6", "epc kept", epc_o, 64'h2000);
        check("R6", "bd kept", 64'(bd_o), 64'h0);
        step("R9", 0, 4'd0, 64'h0, 0, 0, 64'h0, 1);
    endtask

    task automatic t_causes();
        for (int k = 0; k < 16; k++) begin
            step("R7", 1, 4'(k), 64'(k * 16), 0, 0, 64'h0, 0);
            check("R8", "exl set", 64'(exl_o), 64'h1);
            step("R9", 0, 4'd0, 64'h0, 0, 0, 64'h0, 1);
        end
    endtask

    task automatic t_collision();
        step("R10", 1, 4'd0, 64'h7000, 0, 0, 64'h0, 1);
        check("R10", "exl after both", 64'(exl_o), 64'h1);
        check("R10", "vector wins", next_pc_o, 64'hFFFF_FFFF_8000_0180);
        step("R9", 0, 4'd0, 64'h0, 0, 0, 64'h0, 1);
    endtask

    task automatic t_idle();
        step("R11", 1, 4'd13, 64'hABC0, 1, 1, 64'h55, 0);
        for (int i = 0; i < 4; i++)
            step("R11", 0, 4'(i + 3), 64'hFFFF_0000 + 64'(i), 1, 1,
                 64'h1234_5678, 0);
        step("R11", 0, 4'd0, 64'h0, 0, 0, 64'h0, 1);
        for (int i = 0; i < 3; i++)
            step("R11", 0, 4'd4, 64'h10, 0, 0, 64'hFF, 0);
    endtask

    initial begin
        t_reset();
        t_bases();
        t_refill();
        t_capbase();
        t_delay();
        t_nested();
        t_causes();
        t_collision();
        t_idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule